// File: doc/BRIEF.md
# Serial ADC Chip-Select Output Interface

This block is the digital output side of a single 16-bit converter that shares a serial bus with other devices. Each device has its own active-low select line. A rising edge on the convert line, seen while select is high, starts a conversion. The block then times the conversion with a counter clocked by the system clock. When the counter expires, the block latches the result word, enters the acquisition phase and raises a power-down flag.

The host reads the word by pulling select low. The most significant bit appears on the data line at once, and each later falling edge of the serial clock presents the next lower bit. The line is released to high impedance after the sixteenth falling edge, or earlier if select returns high. The release lets the next device on the bus be read.

When convert and select are both low, the line is driven low instead of floating. If select is pulled low late in a conversion, the block flags the busy condition and does not produce it.

All inputs are sampled on the system clock, and every output is a register. An input change is therefore visible on the outputs one clock edge later.

Top module: `adc_cs_serout`

## Requirements
- R1: After synchronous reset, sdo_oe, sdo, converting, pwr_down and busy_err are all 0.
- R2: A convert rising edge with sel_n high sets converting one cycle later and keeps sdo_oe at 0.
- R3: converting stays high for exactly T_MAX cycles. It then falls, and pwr_down rises in the same cycle.
- R4: In the acquisition phase, sel_n going low sets sdo_oe and puts bit 15 (MSB) of the latched word on sdo one cycle later.
- R5: While reading, each serial clock falling edge moves sdo to the next lower bit, so the bits come out in order 15 down to 0.
- R6: The 16th serial clock falling edge of a read clears sdo_oe.
- R7: sel_n high clears sdo_oe on the next cycle, even mid-word. A later sel_n low restarts the read from bit 15.
- R8: cnv low together with sel_n low drives sdo_oe=1 and sdo=0. sel_n low while cnv is high and no read is in progress leaves sdo_oe at 0.
- R9: sel_n low during a conversion when the cycle count is at least T_MIN sets busy_err, which stays set until the next conversion starts. sel_n low only before T_MIN leaves busy_err at 0.
- R10: The word read out is result_in as it stood at the end of the conversion. Later changes to result_in do not alter it.
- R11: A convert rising edge while sel_n is low starts no conversion, so converting stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv | input | 1 | Convert line |
| sel_n | input | 1 | Active-low select line |
| sck | input | 1 | Serial clock |
| result_in | input | 16 | Result from the conversion stub |
| sdo_oe | output | 1 | Data line output enable (0 = high impedance) |
| sdo | output | 1 | Data line value when enabled |
| converting | output | 1 | Conversion phase in progress |
| pwr_down | output | 1 | Acquisition phase, powered down |
| busy_err | output | 1 | Late select during conversion detected |

## Verification
The assertions check the following on every cycle:
- select high always releases the line on the next cycle;
- a read is only ever in progress during the acquisition phase;
- a driven line outside a read carries 0;
- the conversion counter stays within its range;
- the power-down flag appears only in acquisition;
- the busy flag can only rise out of a conversion.

Only the bench's scenarios can show the following:
- the exact conversion length;
- the order of the bits on the line;
- the release on the sixteenth edge;
- the restart from the MSB after an aborted read;
- immunity of the latched word to later changes on result_in;
- the busy window boundaries.

// File: rtl/adc_cs_pkg.sv
package adc_cs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_ACQ  = 2'd2
  } phase_e;
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
  parameter int N = 2,
  parameter logic [N-1:0] RISE_MASK = '1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] edge_o
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev[i] <= RST_VAL[i];
      else     prev[i] <= din[i];
    end
    if (RISE_MASK[i]) begin : g_rise
      assign edge_o[i] = din[i] & ~prev[i];
    end else begin : g_fall
      assign edge_o[i] = ~din[i] & prev[i];
    end
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_cs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int T_MIN  = 8,
  parameter int T_MAX  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sel_n,
  input  logic [DATA_W-1:0] result_in,
  output phase_e            phase,
  output logic              pwr_down,
  output logic              busy_err,
  output logic [DATA_W-1:0] word
);
  localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(T_MAX - 1);
  localparam logic [CNT_W-1:0] MINC = CNT_W'(T_MIN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      pwr_down <= 1'b0;
      busy_err <= 1'b0;
      word     <= '0;
    end else if (start) begin
      phase    <= PH_CONV;
      cnt      <= '0;
      pwr_down <= 1'b0;
      busy_err <= 1'b0;
    end else if (phase == PH_CONV) begin
      if (!sel_n && cnt >= MINC) busy_err <= 1'b1;
      if (cnt == LAST) begin
        phase    <= PH_ACQ;
        pwr_down <= 1'b1;
        word     <= result_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONV) |-> (cnt <= LAST));

  // R3
  pd_acq_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (phase == PH_ACQ));

  // R2
  start_conv_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (phase == PH_CONV && !pwr_down));

  // R9
  busy_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_err) |-> $past(phase == PH_CONV));
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acq,
  input  logic              cnv,
  input  logic              sel_n,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] word,
  output logic              sdo_oe,
  output logic              sdo
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] TOP = IDX_W'(DATA_W - 1);

  logic             rd_active;
  logic             rd_done;
  logic [IDX_W-1:0] bidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_active <= 1'b0;
      rd_done   <= 1'b0;
      bidx      <= '0;
      sdo_oe    <= 1'b0;
      sdo       <= 1'b0;
    end else if (!cnv && !sel_n) begin
      rd_active <= 1'b0;
      rd_done   <= 1'b1;
      sdo_oe    <= 1'b1;
      sdo       <= 1'b0;
    end else if (sel_n) begin
      rd_active <= 1'b0;
      rd_done   <= 1'b0;
      sdo_oe    <= 1'b0;
      sdo       <= 1'b0;
    end else if (rd_active) begin
      if (sck_fall) begin
        if (bidx == '0) begin
          rd_active <= 1'b0;
          rd_done   <= 1'b1;
          sdo_oe    <= 1'b0;
          sdo       <= 1'b0;
        end else begin
          bidx <= bidx - 1'b1;
          sdo  <= word[bidx - 1'b1];
        end
      end
    end else if (acq && !rd_done) begin
      rd_active <= 1'b1;
      bidx      <= TOP;
      sdo_oe    <= 1'b1;
      sdo       <= word[DATA_W-1];
    end else begin
      sdo_oe <= 1'b0;
      sdo    <= 1'b0;
    end
  end

  // R7
  sel_release_chk: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> !sdo_oe);

  // R4
  read_in_acq_chk: assert property (@(posedge clk) disable iff (rst)
    rd_active |-> acq);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && !rd_active) |-> !sdo);
endmodule

// File: rtl/adc_cs_serout.sv
module adc_cs_serout
  import adc_cs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int T_MIN  = 8,
  parameter int T_MAX  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv,
  input  logic              sel_n,
  input  logic              sck,
  input  logic [DATA_W-1:0] result_in,
  output logic              sdo_oe,
  output logic              sdo,
  output logic              converting,
  output logic              pwr_down,
  output logic              busy_err
);
  logic [1:0]        edges;
  logic              start;
  phase_e            phase;
  logic [DATA_W-1:0] word;

  adc_edge_det #(
    .N(2),
    .RISE_MASK(2'b01),
    .RST_VAL(2'b00)
  ) u_edge (
    .clk(clk),
    .rst(rst),
    .din({sck, cnv}),
    .edge_o(edges)
  );

  assign start = edges[0] & sel_n;

  adc_conv_timer #(
    .DATA_W(DATA_W),
    .T_MIN(T_MIN),
    .T_MAX(T_MAX)
  ) u_timer (
    .clk(clk),
    .rst(rst),
    .start(start),
    .sel_n(sel_n),
    .result_in(result_in),
    .phase(phase),
    .pwr_down(pwr_down),
    .busy_err(busy_err),
    .word(word)
  );

  adc_shift_out #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk(clk),
    .rst(rst),
    .acq(phase == PH_ACQ),
    .cnv(cnv),
    .sel_n(sel_n),
    .sck_fall(edges[1]),
    .word(word),
    .sdo_oe(sdo_oe),
    .sdo(sdo)
  );

  assign converting = (phase == PH_CONV);
endmodule

// File: tb/sim_adc_cs_serout.sv
module sim_adc_cs_serout;
  localparam int W     = 16;
  localparam int T_MIN = 8;
  localparam int T_MAX = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnv = 1'b0;
  logic sel_n = 1'b1;
  logic sck = 1'b0;
  logic [W-1:0] result_in = '0;
  logic sdo_oe, sdo, converting, pwr_down, busy_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    logic  oe;
    logic  d;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  event smp_ev;

  always #10 clk = ~clk;

  adc_cs_serout #(.DATA_W(W), .T_MIN(T_MIN), .T_MAX(T_MAX)) u0 (
    .clk(clk), .rst(rst), .cnv(cnv), .sel_n(sel_n), .sck(sck),
    .result_in(result_in), .sdo_oe(sdo_oe), .sdo(sdo),
    .converting(converting), .pwr_down(pwr_down), .busy_err(busy_err)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_line(logic oe, logic d, string tag);
    exp_t e;
    e.oe = oe; e.d = d; e.tag = tag;
    exp_q.push_back(e);
    ->smp_ev;
  endtask

  initial begin : monitor
    forever begin
      @(smp_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " oe"}, {31'd0, sdo_oe}, {31'd0, e.oe});
        if (e.oe) chk({e.tag, " sdo"}, {31'd0, sdo}, {31'd0, e.d});
      end
    end
  end

  task automatic conv(int lo_at, output int len, output bit oe_seen);
    cnv = 1'b1;
    sel_n = 1'b1;
    len = 0;
    oe_seen = 0;
    for (int k = 0; k < 4 * T_MAX; k++) begin
      step();
      if (!converting) break;
      if (sdo_oe) oe_seen = 1;
      len++;
      sel_n = (lo_at >= 0 && len >= lo_at && len < lo_at + 2) ? 1'b0 : 1'b1;
    end
    sel_n = 1'b1;
  endtask

  task automatic read_word(logic [W-1:0] w, int nfall, string tag);
    sel_n = 1'b0;
    step();
    expect_line(1'b1, w[W-1], {tag, " R4 msb"});
    for (int i = 1; i <= nfall; i++) begin
      sck = 1'b1;
      step();
      sck = 1'b0;
      step();
      if (i < W) expect_line(1'b1, w[W-1-i], {tag, " R5 bit"});
      else       expect_line(1'b0, 1'b0, {tag, " R6 release"});
    end
    sel_n = 1'b1;
    step();
    expect_line(1'b0, 1'b0, {tag, " R7 sel high"});
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    int len;
    bit oe_seen;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1
    chk("R1 oe", {31'd0, sdo_oe}, 0);
    chk("R1 conv", {31'd0, converting}, 0);
    chk("R1 pd", {31'd0, pwr_down}, 0);
    chk("R1 busy", {31'd0, busy_err}, 0);

    // R2 R3 R10: first conversion, change input after latch
    result_in = 16'hA5C3;
    conv(-1, len, oe_seen);
    chk("R3 conv length", len, T_MAX);
    chk("R2 hi-z during conv", {31'd0, oe_seen}, 0);
    chk("R3 pd", {31'd0, pwr_down}, 1);
    result_in = 16'h1234;
    read_word(16'hA5C3, 16, "R10 word1");

    // R7: abort mid-word then restart from MSB
    read_word(16'hA5C3, 5, "R7 partial");
    read_word(16'hA5C3, 16, "R7 reread");

    // R9 no error: select low before T_MIN
    cnv = 1'b0;
    step();
    result_in = 16'h0F0F;
    conv(1, len, oe_seen);
    chk("R9 no busy", {31'd0, busy_err}, 0);
    chk("R8 no drive with cnv high", {31'd0, oe_seen}, 0);
    chk("R3 conv length 2", len, T_MAX);
    read_word(16'h0F0F, 16, "R5 word2");

    // R9 error: select low after T_MIN
    cnv = 1'b0;
    step();
    result_in = 16'hFFFE;
    conv(12, len, oe_seen);
    chk("R9 busy set", {31'd0, busy_err}, 1);
    step();
    chk("R9 busy sticky", {31'd0, busy_err}, 1);
    read_word(16'hFFFE, 16, "R6 word3");

    // new conversion clears busy
    cnv = 1'b0;
    step();
    cnv = 1'b1;
    step();
    chk("R2 conv start", {31'd0, converting}, 1);
    chk("R9 busy cleared", {31'd0, busy_err}, 0);
    conv(-1, len, oe_seen);

    // R8: both low drives low
    cnv = 1'b0;
    sel_n = 1'b0;
    step();
    expect_line(1'b1, 1'b0, "R8 both low");
    sel_n = 1'b1;
    step();
    expect_line(1'b0, 1'b0, "R8 released");

    // R11: convert edge with select low starts nothing
    sel_n = 1'b0;
    step();
    cnv = 1'b1;
    step();
    step();
    chk("R11 no conv", {31'd0, converting}, 0);
    sel_n = 1'b1;
    cnv = 1'b0;
    step();
    step();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule